// File: doc/BRIEF.md
# Sign-Gated Clamp Parameter Stepper

This block computes the training update for the two parameters attached to one input of a neuron that has no multiplier in its forward path. One parameter sets a magnitude ceiling on the input's contribution. The other sets a leakage ceiling. Each clock cycle in which `in_valid` is high, the block takes the neuron's signed error term, one input sample and the two parameters for that input. It returns both parameters updated.

A parameter moves only while it is the limiting value, which means its magnitude is strictly below that of the input. When it moves, the direction comes from the signs of the input and of the parameter. The step size is the error term arithmetically shifted right by a runtime shift amount. That shift stands for the learning rate and the fan-in normalisation, so the block contains only comparators, adders and multiplexers. Results are clamped to the representable range instead of wrapping.

The block counts accepted samples from 0 to `FAN_IN`-1 and reports the index of every result. It raises a one-cycle `done` with the result for the last index of the neuron. Producing the error term and storing the parameters are left to the surrounding logic.

Top module: `param_sign_stepper`

## Requirements
- R1: The width parameter `w_in` changes only when |`w_in`| < |`x_in`| (strict); if the magnitudes are equal or |`w_in`| is larger, `w_out` equals `w_in`.
- R2: The leakage parameter `n_in` obeys the same strict rule against |`x_in`|, independently of `w_in`, and both results appear in the same output cycle.
- R3: When a parameter is allowed to move, the result is parameter minus step if the parameter and `x_in` have the same sign, and parameter plus step if their signs differ.
- R4: The step equals `err_in` (two's complement) arithmetically shifted right by `shift_in` bits, so it rounds toward minus infinity (for example -7 shifted by 1 gives -4).
- R5: A zero `x_in` or a zero parameter produces no change to that parameter.
- R6: A result above +2^(DW-1)-1 is clamped to that value, and a result below -2^(DW-1) is clamped to -2^(DW-1).
- R7: Outputs are registered. `out_valid` is high in the cycle after an accepted sample and low in the cycle after an idle one.
- R8: Accepted samples are numbered 0,1,…,`FAN_IN`-1 and then back to 0. `out_idx` carries the number of each result, and `done` is high only together with the result whose index is `FAN_IN`-1.
- R9: A synchronous active-low reset clears `out_valid`, `done`, `w_out`, `n_out` and `out_idx`, and restarts the numbering at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample present this cycle |
| err_in | input | EW | Signed error term of the neuron |
| shift_in | input | SHW | Right-shift amount that sets the step |
| x_in | input | DW | Signed input sample |
| w_in | input | DW | Current width (clamp) parameter |
| n_in | input | DW | Current leakage parameter |
| out_valid | output | 1 | Updated parameters valid |
| w_out | output | DW | Updated width parameter |
| n_out | output | DW | Updated leakage parameter |
| out_idx | output | IDXW | Index of the result within the neuron |
| done | output | 1 | Result for the last index |

## Verification
The bench targets equal magnitudes. A gate written as non-strict would move the parameter in that case when it should hold it. It pairs odd negative error terms with shifts, where a rounding-toward-zero step comes out one too small. It also pushes sums past both ends of the parameter range, where a design without clamping would wrap to the opposite sign. Zero inputs and zero parameters are checked for an unwanted step. A reset in the middle of a neuron tests whether the numbering restarts, since a counter that survived reset would raise `done` at the wrong sample.

// File: rtl/pstep_pkg.sv
// Shared types for the parameter stepper.
// Assumes nothing beyond the encoding of the update direction.
package pstep_pkg;
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_SUB  = 2'd1,
        STEP_ADD  = 2'd2
    } step_dir_e;
endpackage

// File: rtl/pstep_gate.sv
// Decides whether a parameter is the limiting value for an input sample,
// and if so in which direction it moves.
// Assumes two's complement operands of equal width; zero counts as sign 0.
module pstep_gate
    import pstep_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic signed [DW-1:0] x,
    input  logic signed [DW-1:0] p,
    output step_dir_e            dir
);
    logic signed [DW:0] x_ext, p_ext;
    logic        [DW:0] x_mag, p_mag;
    logic               x_zero, p_zero, active;

    // magnitudes with one extra bit so the most negative value is exact
    always_comb begin
        x_ext = {x[DW-1], x};
        p_ext = {p[DW-1], p};
        x_mag = x_ext[DW] ? $unsigned(-x_ext) : $unsigned(x_ext);
        p_mag = p_ext[DW] ? $unsigned(-p_ext) : $unsigned(p_ext);
    end

    // strict comparison gate with zero-sign suppression
    always_comb begin
        x_zero = (x == '0);
        p_zero = (p == '0);
        active = !x_zero && !p_zero && (p_mag < x_mag);
        if (!active)
            dir = STEP_HOLD;
        else if (x[DW-1] == p[DW-1])
            dir = STEP_SUB;
        else
            dir = STEP_ADD;
    end
endmodule

// File: rtl/pstep_apply.sv
// Applies a signed step to a parameter in the chosen direction and clamps
// the result to the parameter's signed range.
// Assumes the step is already scaled; the sum is formed two bits wider.
module pstep_apply
    import pstep_pkg::*;
#(
    parameter int DW = 8,
    parameter int EW = 12
) (
    input  logic signed [DW-1:0] p,
    input  logic signed [EW-1:0] step,
    input  step_dir_e            dir,
    output logic signed [DW-1:0] p_next
);
    localparam int WW = ((EW > DW) ? EW : DW) + 2;
    localparam logic signed [WW-1:0] TOP_W = $signed({{(WW-DW+1){1'b0}}, {(DW-1){1'b1}}});
    localparam logic signed [WW-1:0] BOT_W = $signed({{(WW-DW+1){1'b1}}, {(DW-1){1'b0}}});

    logic signed [WW-1:0] p_w, s_w, sum_w;

    // wide sum in the selected direction
    always_comb begin
        p_w = WW'(p);
        s_w = WW'(step);
        case (dir)
            STEP_SUB: sum_w = p_w - s_w;
            STEP_ADD: sum_w = p_w + s_w;
            default:  sum_w = p_w;
        endcase
    end

    // clamp to the representable range
    always_comb begin
        if (sum_w > TOP_W)
            p_next = TOP_W[DW-1:0];
        else if (sum_w < BOT_W)
            p_next = BOT_W[DW-1:0];
        else
            p_next = sum_w[DW-1:0];
    end
endmodule

// File: rtl/pstep_index.sv
// Numbers accepted samples of one neuron from 0 to FAN_IN-1 and wraps.
// Assumes one advance per accepted sample; reset is synchronous, active low.
module pstep_index #(
    parameter int FAN_IN = 4,
    localparam int IDXW  = (FAN_IN > 1) ? $clog2(FAN_IN) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    output logic [IDXW-1:0] idx,
    output logic            last
);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(FAN_IN - 1);

    logic [IDXW-1:0] idx_q;

    assign idx  = idx_q;
    assign last = (idx_q == LAST_IDX);

    // advance and wrap the sample number
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (adv)
            idx_q <= last ? '0 : idx_q + IDXW'(1);
    end
endmodule

// File: rtl/param_sign_stepper.sv
// Updates the width and leakage parameters of one neuron input per cycle.
// Each lane gates its parameter by a strict magnitude compare against the
// input, steps by the shifted error term and clamps. Results are registered.
// Assumes the caller supplies stored parameters and the error term.
module param_sign_stepper
    import pstep_pkg::*;
#(
    parameter int DW     = 8,
    parameter int EW     = 12,
    parameter int SHW    = 4,
    parameter int FAN_IN = 4,
    localparam int IDXW  = (FAN_IN > 1) ? $clog2(FAN_IN) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic signed [EW-1:0]  err_in,
    input  logic [SHW-1:0]        shift_in,
    input  logic signed [DW-1:0]  x_in,
    input  logic signed [DW-1:0]  w_in,
    input  logic signed [DW-1:0]  n_in,
    output logic                  out_valid,
    output logic signed [DW-1:0]  w_out,
    output logic signed [DW-1:0]  n_out,
    output logic [IDXW-1:0]       out_idx,
    output logic                  done
);
    localparam int LANES = 2;

    logic signed [EW-1:0] step;
    logic signed [DW-1:0] p_cur [LANES];
    logic signed [DW-1:0] p_nxt [LANES];
    step_dir_e            dir   [LANES];
    logic [IDXW-1:0]      idx_now;
    logic                 idx_last;

    // scaled step: learning rate and normalisation as one arithmetic shift
    assign step     = err_in >>> shift_in;
    assign p_cur[0] = w_in;
    assign p_cur[1] = n_in;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pstep_gate #(.DW(DW)) u_gate (
            .x   (x_in),
            .p   (p_cur[g]),
            .dir (dir[g])
        );
        pstep_apply #(.DW(DW), .EW(EW)) u_apply (
            .p      (p_cur[g]),
            .step   (step),
            .dir    (dir[g]),
            .p_next (p_nxt[g])
        );
    end

    pstep_index #(.FAN_IN(FAN_IN)) u_index (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (in_valid),
        .idx   (idx_now),
        .last  (idx_last)
    );

    // output register for both lanes, the index and the end marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            done      <= 1'b0;
            w_out     <= '0;
            n_out     <= '0;
            out_idx   <= '0;
        end else begin
            out_valid <= in_valid;
            done      <= in_valid && idx_last;
            if (in_valid) begin
                w_out   <= p_nxt[0];
                n_out   <= p_nxt[1];
                out_idx <= idx_now;
            end
        end
    end

    // R1
    equal_mag_w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (w_in == x_in) |=> w_out == $past(w_in));

    // R2
    equal_mag_n_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (n_in == x_in) |=> n_out == $past(n_in));

    // R5
    zero_input_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (x_in == '0) |=> (w_out == $past(w_in)) && (n_out == $past(n_in)));

    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !err_in[EW-1] && !x_in[DW-1] && !w_in[DW-1]
        |=> $signed(w_out) <= $signed($past(w_in)));

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> out_valid && (out_idx == IDXW'(FAN_IN - 1)));
endmodule

// File: tb/param_sign_stepper_test.sv
module param_sign_stepper_test;
    localparam int DW = 8, EW = 12, SHW = 4, FAN_IN = 4;
    localparam int IDXW = 2;

    typedef struct packed {
        int err; int sh; int x; int w; int n; int ew; int en;
    } vec_t;

    // err, shift, x, w, n, expected w, expected n
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{16,   2,  50,  10,  60,   6,   60},   // R1 R3 same sign, n above x
        '{16,   2,  50, -10,  50,  -6,   50},   // R3 opposite sign, R2 equal mag
        '{-8,   0, -30,  20,  -5,  12,    3},   // R3 R4 negative step
        '{-7,   1,  40,   5,  -5,   9,   -9},   // R4 floor rounding
        '{7,    1,  40,   5,  -5,   2,   -2},   // R4 positive shift
        '{100,  0,   0,   5,  -5,   5,   -5},   // R5 zero input
        '{2000, 0, 127,-100, 100, 127, -128},   // R6 both clamps
        '{-2000,0,-128,-120, 120, 127, -128},   // R6 both clamps, x min
        '{-1,  15,  10,   3,  -3,   4,   -4},   // R4 shift keeps -1
        '{5,   15,  10,   3,   3,   3,    3}    // R4 shift to zero
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [EW-1:0] err_in = '0;
    logic [SHW-1:0] shift_in = '0;
    logic signed [DW-1:0] x_in = '0, w_in = '0, n_in = '0;
    logic out_valid, done;
    logic signed [DW-1:0] w_out, n_out;
    logic [IDXW-1:0] out_idx;

    int n_checks = 0;
    int n_fail = 0;
    int sent = 0;

    always #2 clk = ~clk;

    param_sign_stepper #(.DW(DW), .EW(EW), .SHW(SHW), .FAN_IN(FAN_IN)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .err_in(err_in), .shift_in(shift_in),
        .x_in(x_in), .w_in(w_in), .n_in(n_in),
        .out_valid(out_valid), .w_out(w_out), .n_out(n_out),
        .out_idx(out_idx), .done(done)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // drive one sample at a falling edge, look at the result one edge later
    task automatic apply(input vec_t v, input string tag);
        int exp_idx;
        exp_idx = sent % FAN_IN;
        @(negedge clk);
        in_valid = 1'b1;
        err_in = EW'(v.err); shift_in = SHW'(v.sh);
        x_in = DW'(v.x); w_in = DW'(v.w); n_in = DW'(v.n);
        @(negedge clk);
        in_valid = 1'b0;
        sent++;
        check({tag, " R7 out_valid"}, int'(out_valid), 1);
        check({tag, " R1 R3 w_out"}, int'(w_out), v.ew);
        check({tag, " R2 n_out"}, int'(n_out), v.en);
        check({tag, " R8 out_idx"}, int'(out_idx), exp_idx);
        check({tag, " R8 done"}, int'(done), (exp_idx == FAN_IN - 1) ? 1 : 0);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 out_valid", int'(out_valid), 0);
        check("R9 done", int'(done), 0);
        check("R9 w_out", int'(w_out), 0);
        check("R9 n_out", int'(n_out), 0);
        check("R9 out_idx", int'(out_idx), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++)
            apply(VECS[i], $sformatf("vec%0d", i));

        // R7 idle cycle gives no result
        @(negedge clk);
        check("R7 idle out_valid", int'(out_valid), 0);
        check("R8 idle done", int'(done), 0);

        // R5 zero parameters with a large step
        apply('{100, 0, 40, 0, 0, 0, 0}, "R5 zero params");

        // R1 parameter above the input magnitude
        apply('{-300, 0, 12, -13, 13, -13, 13}, "R1 above");

        // R9 reset mid-neuron restarts numbering
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R9 mid reset out_valid", int'(out_valid), 0);
        sent = 0;
        for (int i = 0; i < FAN_IN; i++)
            apply(VECS[i], $sformatf("R9 after reset %0d", i));

        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule